// File: doc/BRIEF.md
# Dual Program Counter Fetch Unit with Two-Thread Mode

This block produces the two fetch addresses of a two-wide instruction front end. Two program-counter registers feed two fetch buffers. In lockstep mode the two counters belong to one thread. The second counter always points one instruction past the first, so each unstalled cycle fetches a pair of consecutive instructions and both counters advance by two instructions.

In two-thread mode the same registers become the program counters of hardware thread 0 and hardware thread 1. Each advances by one instruction per unstalled cycle and follows redirects tagged with its own thread number. Turning the mode on leaves the second counter where it is, so thread 1 begins at the instruction after thread 0, much like a fork. Turning the mode off drops thread 1's stream and pulls the second counter back to one instruction past the first.

The unit also reports the thread number of each fetch lane and the register-set index that each lane's thread uses. The two indices are the even and odd members of a pair. A single instruction-cache miss input stalls both counters together.

Top module: `dual_pc_fetch`

## Requirements
- R1: While rst_n is low at a clock edge, pc0 becomes RESET_VEC (default 0x1000), pc1 becomes RESET_VEC + 4, and smt_on becomes 0.
- R2: In lockstep mode (smt_on = 0), pc1 equals pc0 + 4 in every cycle. An unstalled cycle with no redirect adds 8 to both counters.
- R3: In lockstep mode, a branch (br_valid, applied only when unstalled) or a flush (flush_valid) loads pc0 with the target and pc1 with the target + 4, whatever the thread tag.
- R4: In two-thread mode (smt_on = 1), an unstalled cycle with no redirect for a thread adds 4 to that thread's counter. pc0 belongs to thread 0 and pc1 to thread 1, and each advances independently.
- R5: In two-thread mode, a redirect tagged with thread t (br_tid or flush_tid, 0 or 1) loads only counter t. The other counter follows its own rule in the same cycle.
- R6: When a flush and a branch name the same counter in one cycle, the flush target wins.
- R7: While icache_miss is 1, both counters and the mode hold, and branches are ignored. A flush still loads its counter(s).
- R8: smt_on takes the value of smt_req at a clock edge only if icache_miss is 0 in that cycle. A request made during a stall waits until the stall ends.
- R9: On the edge where the mode turns on, pc1 becomes the updated pc0 + 4 and then continues from there as thread 1. It is never reloaded with RESET_VEC.
- R10: On the edge where the mode turns off, pc1 becomes the updated pc0 + 4. Any thread-1 redirect in that cycle is discarded.
- R11: lane0_tid is always 0. lane1_tid equals smt_on.
- R12: lane0_regset is regset_base with bit 0 cleared. lane1_regset is regset_base with bit 0 set when smt_on is 1, and equals lane0_regset when smt_on is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| smt_req | input | 1 | Requested mode: 1 = two threads, 0 = lockstep |
| icache_miss | input | 1 | Instruction-cache miss; stalls both counters |
| br_valid | input | 1 | Front-end branch redirect |
| br_tid | input | 1 | Thread of the branch (used in two-thread mode) |
| br_target | input | PC_W | Branch target address |
| flush_valid | input | 1 | Back-end redirect, applied even while stalled |
| flush_tid | input | 1 | Thread of the flush (used in two-thread mode) |
| flush_target | input | PC_W | Flush target address |
| regset_base | input | RS_W | Register-set pair selector |
| pc0 | output | PC_W | Fetch address of lane 0 |
| pc1 | output | PC_W | Fetch address of lane 1 |
| smt_on | output | 1 | Current mode |
| lane0_tid | output | 1 | Thread number of lane 0 |
| lane1_tid | output | 1 | Thread number of lane 1 |
| lane0_regset | output | RS_W | Register-set index for lane 0 |
| lane1_regset | output | RS_W | Register-set index for lane 1 |

## Verification
The assertions assume that targets are word aligned and that reset has run before any redirect arrives. They make no other assumption about the order of inputs: a flush may coincide with a stall, with a branch to the same thread, or with a mode change. The random stimulus therefore clears the low two bits of every target. It raises each control input independently with moderate probability, so that stalls overlap mode requests and redirects, and both mode edges occur many times. Directed sequences then pin down the fork and snap-back edges and the deferral of a mode request held during a stall.

// File: rtl/dpc_pkg.sv
// Package: shared types for the dual program counter fetch unit.
// Assumes: two fetch lanes and at most two hardware threads.
package dpc_pkg;

    // Fetch mode: one thread over both lanes, or one thread per lane.
    typedef enum logic {
        MODE_LOCKSTEP = 1'b0,
        MODE_DUAL     = 1'b1
    } fetch_mode_e;

    // Hardware thread number.
    typedef logic thread_id_t;

    localparam int NUM_LANES = 2;

endpackage

// File: rtl/dpc_mode_ctl.sv
// Module: mode register. Takes the requested mode only on unstalled cycles,
// so no fetch slot is lost while the lanes change meaning.
// Assumes: stall is a registered-clean signal for the current cycle.
module dpc_mode_ctl
    import dpc_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        mode_req,
    input  logic        stall,
    output fetch_mode_e mode_q,
    output fetch_mode_e mode_d
);

    // Next mode: hold during a stall, else follow the request.
    always_comb begin
        mode_d = stall ? mode_q : fetch_mode_e'(mode_req);
    end

    // Mode register with synchronous reset to lockstep.
    always_ff @(posedge clk) begin
        if (!rst_n) mode_q <= MODE_LOCKSTEP;
        else        mode_q <= mode_d;
    end

    AST_MODE_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> $stable(mode_q)); // R7

    AST_MODE_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        !stall |=> (mode_q == fetch_mode_e'($past(mode_req)))); // R8

endmodule

// File: rtl/dpc_lane_next.sv
// Module: per-thread next address for two-thread mode. One instance per lane;
// LANE is the thread that owns it.
// Assumes: flush beats branch; branch is dropped on a stall, flush is not.
module dpc_lane_next
    import dpc_pkg::*;
#(
    parameter int PC_W       = 32,
    parameter int INSN_BYTES = 4,
    parameter int LANE       = 0
) (
    input  logic            stall,
    input  logic [PC_W-1:0] pc_q,
    input  logic            br_valid,
    input  thread_id_t      br_tid,
    input  logic [PC_W-1:0] br_target,
    input  logic            flush_valid,
    input  thread_id_t      flush_tid,
    input  logic [PC_W-1:0] flush_target,
    output logic [PC_W-1:0] pc_d
);

    localparam thread_id_t      OWN_TID = thread_id_t'(LANE);
    localparam logic [PC_W-1:0] STEP    = PC_W'(INSN_BYTES);

    logic flush_hit;
    logic br_hit;

    // Decide whether a redirect addresses this thread.
    always_comb begin
        flush_hit = flush_valid && (flush_tid == OWN_TID);
        br_hit    = br_valid && (br_tid == OWN_TID) && !stall;
    end

    // Priority: flush, branch, sequential step, hold.
    always_comb begin
        if (flush_hit)   pc_d = flush_target;
        else if (br_hit) pc_d = br_target;
        else if (!stall) pc_d = pc_q + STEP;
        else             pc_d = pc_q;
    end

endmodule

// File: rtl/dpc_thread_map.sv
// Module: maps the current mode to per-lane thread numbers and register-set
// indices drawn from an even/odd pair.
// Assumes: regset_base names the pair; its bit 0 is overridden.
module dpc_thread_map
    import dpc_pkg::*;
#(
    parameter int RS_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  fetch_mode_e     mode_q,
    input  logic [RS_W-1:0] regset_base,
    output thread_id_t      lane0_tid,
    output thread_id_t      lane1_tid,
    output logic [RS_W-1:0] lane0_regset,
    output logic [RS_W-1:0] lane1_regset
);

    logic [RS_W-1:0] even_idx;
    logic [RS_W-1:0] odd_idx;

    // Form the even and odd members of the selected pair.
    always_comb begin
        even_idx = regset_base & ~RS_W'(1);
        odd_idx  = regset_base |  RS_W'(1);
    end

    // Lane 1 is thread 1 only in two-thread mode.
    always_comb begin
        lane0_tid    = 1'b0;
        lane1_tid    = (mode_q == MODE_DUAL);
        lane0_regset = even_idx;
        lane1_regset = (mode_q == MODE_DUAL) ? odd_idx : even_idx;
    end

    AST_LANE0_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
        lane0_regset[0] == 1'b0); // R12

    AST_LANE1_ODD: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_DUAL) |-> (lane1_regset[0] && lane1_tid)); // R11

endmodule

// File: rtl/dual_pc_fetch.sv
// Module: top of the dual program counter fetch unit. Holds the two counters
// and selects between lockstep and per-thread next addresses.
// Assumes: targets are aligned to INSN_BYTES; RESET_VEC is aligned too.
module dual_pc_fetch
    import dpc_pkg::*;
#(
    parameter int              PC_W       = 32,
    parameter int              INSN_BYTES = 4,
    parameter int              RS_W       = 4,
    parameter logic [PC_W-1:0] RESET_VEC  = 32'h0000_1000
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            smt_req,
    input  logic            icache_miss,
    input  logic            br_valid,
    input  logic            br_tid,
    input  logic [PC_W-1:0] br_target,
    input  logic            flush_valid,
    input  logic            flush_tid,
    input  logic [PC_W-1:0] flush_target,
    input  logic [RS_W-1:0] regset_base,
    output logic [PC_W-1:0] pc0,
    output logic [PC_W-1:0] pc1,
    output logic            smt_on,
    output logic            lane0_tid,
    output logic            lane1_tid,
    output logic [RS_W-1:0] lane0_regset,
    output logic [RS_W-1:0] lane1_regset
);

    localparam logic [PC_W-1:0] STEP      = PC_W'(INSN_BYTES);
    localparam logic [PC_W-1:0] PAIR_STEP = PC_W'(2 * INSN_BYTES);

    fetch_mode_e     mode_q;
    fetch_mode_e     mode_d;
    logic [PC_W-1:0] pc_q [NUM_LANES];
    logic [PC_W-1:0] lane_d [NUM_LANES];
    logic [PC_W-1:0] lock_d;
    logic [PC_W-1:0] pc0_d;
    logic [PC_W-1:0] pc1_d;

    dpc_mode_ctl u_mode (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode_req (smt_req),
        .stall    (icache_miss),
        .mode_q   (mode_q),
        .mode_d   (mode_d)
    );

    // One independent next-address unit per thread lane.
    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
        dpc_lane_next #(
            .PC_W       (PC_W),
            .INSN_BYTES (INSN_BYTES),
            .LANE       (g)
        ) u_next (
            .stall        (icache_miss),
            .pc_q         (pc_q[g]),
            .br_valid     (br_valid),
            .br_tid       (br_tid),
            .br_target    (br_target),
            .flush_valid  (flush_valid),
            .flush_tid    (flush_tid),
            .flush_target (flush_target),
            .pc_d         (lane_d[g])
        );
    end

    // Lockstep next address for lane 0: redirects ignore the thread tag.
    always_comb begin
        if (flush_valid)                  lock_d = flush_target;
        else if (br_valid && !icache_miss) lock_d = br_target;
        else if (!icache_miss)             lock_d = pc_q[0] + PAIR_STEP;
        else                               lock_d = pc_q[0];
    end

    // Select per current mode; lane 1 tracks lane 0 unless dual on both sides.
    always_comb begin
        pc0_d = (mode_q == MODE_DUAL) ? lane_d[0] : lock_d;
        if (mode_q == MODE_DUAL && mode_d == MODE_DUAL) pc1_d = lane_d[1];
        else                                            pc1_d = pc0_d + STEP;
    end

    // Counter registers with synchronous reset to the reset vector pair.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q[0] <= RESET_VEC;
            pc_q[1] <= RESET_VEC + STEP;
        end else begin
            pc_q[0] <= pc0_d;
            pc_q[1] <= pc1_d;
        end
    end

    dpc_thread_map #(.RS_W(RS_W)) u_map (
        .clk          (clk),
        .rst_n        (rst_n),
        .mode_q       (mode_q),
        .regset_base  (regset_base),
        .lane0_tid    (lane0_tid),
        .lane1_tid    (lane1_tid),
        .lane0_regset (lane0_regset),
        .lane1_regset (lane1_regset)
    );

    // Drive the output ports from the registers.
    always_comb begin
        pc0    = pc_q[0];
        pc1    = pc_q[1];
        smt_on = (mode_q == MODE_DUAL);
    end

    AST_LOCKSTEP_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        !smt_on |-> (pc1 == pc0 + STEP)); // R2

    AST_STALL_HOLDS_PC: assert property (@(posedge clk) disable iff (!rst_n)
        (icache_miss && !flush_valid) |=> ($stable(pc0) && $stable(pc1))); // R7

    AST_DUAL_STEP0: assert property (@(posedge clk) disable iff (!rst_n)
        (smt_on && !icache_miss && !(flush_valid && !flush_tid)
         && !(br_valid && !br_tid)) |=> (pc0 == $past(pc0) + STEP)); // R4

    AST_FLUSH_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_valid && (!smt_on || !flush_tid)) |=> (pc0 == $past(flush_target))); // R6

    AST_SNAP_BACK: assert property (@(posedge clk) disable iff (!rst_n)
        (smt_on && !icache_miss && !smt_req) |=> (!smt_on && pc1 == pc0 + STEP)); // R10

endmodule

// File: tb/tb_dual_pc_fetch.sv
module tb_dual_pc_fetch;

    localparam int          PC_W = 32;
    localparam int          RS_W = 4;
    localparam logic [31:0] RV   = 32'h0000_1000;

    logic            clk = 1'b0;
    logic            rst_n;
    logic            smt_req, icache_miss, br_valid, br_tid, flush_valid, flush_tid;
    logic [PC_W-1:0] br_target, flush_target;
    logic [RS_W-1:0] regset_base;
    logic [PC_W-1:0] pc0, pc1;
    logic            smt_on, lane0_tid, lane1_tid;
    logic [RS_W-1:0] lane0_regset, lane1_regset;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    logic [PC_W-1:0] e0, e1;
    logic            em;

    always #2 clk = ~clk;

    dual_pc_fetch #(.PC_W(PC_W), .RS_W(RS_W), .RESET_VEC(RV)) dut (.*);

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            fails = fails + 1;
            $display("FAIL watchdog: actual %0d cycles expected < 150000", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks = checks + 1;
        if (act !== exp) begin
            fails = fails + 1;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Expected-state update from the requirements, for one clock edge.
    task automatic model_step();
        logic [PC_W-1:0] n0, n1, l1;
        logic nm;
        if (!rst_n) begin
            e0 = RV; e1 = RV + 4; em = 1'b0;
            return;
        end
        if (!em) begin
            n0 = flush_valid ? flush_target :
                 (br_valid && !icache_miss) ? br_target :
                 !icache_miss ? e0 + 8 : e0;
            l1 = n0 + 4;
        end else begin
            n0 = (flush_valid && !flush_tid) ? flush_target :
                 (br_valid && !br_tid && !icache_miss) ? br_target :
                 !icache_miss ? e0 + 4 : e0;
            l1 = (flush_valid && flush_tid) ? flush_target :
                 (br_valid && br_tid && !icache_miss) ? br_target :
                 !icache_miss ? e1 + 4 : e1;
        end
        nm = icache_miss ? em : smt_req;
        n1 = (em && nm) ? l1 : n0 + 4;
        e0 = n0; e1 = n1; em = nm;
    endtask

    task automatic set_in(input logic req, input logic miss, input logic bv, input logic bt,
                          input logic [31:0] btg, input logic fv, input logic ft,
                          input logic [31:0] ftg);
        smt_req = req; icache_miss = miss; br_valid = bv; br_tid = bt; br_target = btg;
        flush_valid = fv; flush_tid = ft; flush_target = ftg;
    endtask

    // Apply inputs at a falling edge, advance one clock, compare at the next falling edge.
    task automatic cycle(input string req);
        model_step();
        @(negedge clk);
        chk({req, " pc0"}, 64'(pc0), 64'(e0));
        chk({req, " pc1"}, 64'(pc1), 64'(e1));
        chk({req, " mode"}, 64'(smt_on), 64'(em));
    endtask

    task automatic chk_map(input string tag);
        chk({tag, " R11 lane0_tid"}, 64'(lane0_tid), 64'd0);
        chk({tag, " R11 lane1_tid"}, 64'(lane1_tid), 64'(em));
        chk({tag, " R12 lane0_regset"}, 64'(lane0_regset), 64'(regset_base & 4'hE));
        chk({tag, " R12 lane1_regset"}, 64'(lane1_regset),
            64'(em ? (regset_base | 4'h1) : (regset_base & 4'hE)));
    endtask

    initial begin
        void'($urandom(32'd1234));
        rst_n = 1'b0; regset_base = 4'd5;
        set_in(1'b1, 1'b0, 1'b0, 1'b0, 0, 1'b0, 1'b0, 0);
        @(negedge clk);
        cycle("R1 reset");
        chk("R1 reset pc0", 64'(pc0), 64'(RV));
        chk("R1 reset pc1", 64'(pc1), 64'(RV + 4));
        chk_map("reset");
        rst_n = 1'b1;

        // Lockstep sequential, then branch with thread tag 1 (ignored).
        set_in(1'b0, 1'b0, 1'b0, 1'b0, 0, 1'b0, 1'b0, 0);
        cycle("R2 seq");
        chk("R2 pc0 step 8", 64'(pc0), 64'(RV + 8));
        set_in(1'b0, 1'b0, 1'b1, 1'b1, 32'h2000, 1'b0, 1'b0, 0);
        cycle("R3 branch");
        chk("R3 pc1 target+4", 64'(pc1), 64'h2004);

        // Stall: branch ignored, mode request deferred, flush applied.
        set_in(1'b1, 1'b1, 1'b1, 1'b0, 32'h3000, 1'b0, 1'b0, 0);
        cycle("R7 stall br");
        chk("R7 branch ignored", 64'(pc0), 64'h2000);
        chk("R8 mode deferred", 64'(smt_on), 64'd0);
        set_in(1'b1, 1'b1, 1'b1, 1'b0, 32'h3000, 1'b1, 1'b0, 32'h4000);
        cycle("R6 flush over br in stall");
        chk("R6 flush wins", 64'(pc0), 64'h4000);

        // Stall ends: mode turns on; pc1 forks from pc0+4.
        set_in(1'b1, 1'b0, 1'b0, 1'b0, 0, 1'b0, 1'b0, 0);
        cycle("R8 mode on");
        chk("R9 fork pc1", 64'(pc1), 64'h400C);
        chk_map("dual");
        cycle("R4 dual step");
        chk("R4 pc0+4", 64'(pc0), 64'h400C);
        chk("R4 pc1+4", 64'(pc1), 64'h4010);

        // Thread-1 branch changes only pc1; thread-0 flush only pc0.
        set_in(1'b1, 1'b0, 1'b1, 1'b1, 32'h8000, 1'b0, 1'b0, 0);
        cycle("R5 br t1");
        chk("R5 pc0 untouched", 64'(pc0), 64'h4010);
        chk("R5 pc1 target", 64'(pc1), 64'h8000);
        set_in(1'b1, 1'b0, 1'b1, 1'b1, 32'h9000, 1'b1, 1'b1, 32'hA000);
        cycle("R6 dual flush t1");
        chk("R6 flush t1 wins", 64'(pc1), 64'hA000);

        // Turn off with a thread-1 branch: discarded, pc1 snaps to pc0+4.
        set_in(1'b0, 1'b0, 1'b1, 1'b1, 32'hB000, 1'b0, 1'b0, 0);
        cycle("R10 mode off");
        chk("R10 snap", 64'(pc1), 64'(pc0 + 4));
        chk("R10 pc0", 64'(pc0), 64'h4018);
        chk_map("lockstep");

        // Constrained random phase.
        for (int i = 0; i < 4000; i++) begin
            regset_base = 4'($urandom);
            set_in(($urandom % 4) != 0, ($urandom % 5) == 0, ($urandom % 4) == 0, 1'($urandom),
                   $urandom & 32'hFFFF_FFFC, ($urandom % 8) == 0, 1'($urandom),
                   $urandom & 32'hFFFF_FFFC);
            if (em) cycle("R4 R5 R6 R7 random dual");
            else    cycle("R2 R3 R7 R8 random lockstep");
            chk_map("random");
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule